// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer for an 8-bit Processor

This block is the part of a small 8-bit processor that turns pending interrupt sources into bus cycles. At each opcode-fetch cycle it looks at the fetched byte and the request lines. It then takes one of four paths: the software break opcode, a latched non-maskable request, a level-sensitive maskable request, or the return-from-interrupt opcode. Each path drives the address, write data, write strobe and fetch marker cycle by cycle on a single-clock bus.

Entry pushes the return address and the status byte onto page one of memory. It then loads the program counter from a fixed vector. The return path pulls the same three bytes back. A ready input freezes the whole sequencer in any cycle, including stack writes and internal cycles. An active-low set-overflow pin sets the overflow flag.

Opcodes other than break and return are stand-ins for the rest of the processor. They take one fetch cycle and advance the program counter. The full decoder and ALU sit outside this block.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is low, sync and write enable are 0 and status reads 0x34. After release there is one dead cycle with no sync and no write. The block then reads 0xFFFC (low byte) and 0xFFFD (high byte), and the next cycle is a fetch with sync high at the address just loaded.
- R2: At a fetch, a fetched byte of 0x00 (break) wins over a pending non-maskable request, which wins over a maskable request. A request that loses stays pending.
- R3: A hardware entry lasts exactly 7 cycles. Cycle 1 is the fetch with sync high. Cycle 2 reads the same address again, because the fetched byte is discarded. Cycle 8 is a sync fetch at the vector target. No cycle with sync high ever writes.
- R4: Entry writes PC high, then PC low, then status, each to 0x0100 + SP, and decrements SP after each write. The pushed status has bits 5 and 4 set.
- R5: Vectors are read low byte first. The non-maskable vector is at 0xFFFA/0xFFFB. The maskable and break vector is at 0xFFFE/0xFFFF.
- R6: Break reads the byte after the opcode and pushes the opcode address + 2. Every entry sets the interrupt-disable bit (bit 2) and clears the decimal bit (bit 3).
- R7: The maskable request is taken while irq_n is low at a fetch, but only if bit 2 of status is 0.
- R8: A falling edge on nmi_n is latched until it is serviced and is serviced once. Holding nmi_n low does not cause a second entry.
- R9: Return (opcode 0x40) takes 6 cycles. It reads fetch+1, then reads 0x0100+SP, then increments SP before each of three reads: status, PC low, PC high. Status is loaded with bits 5 and 4 forced to 1.
- R10: Status bits 5 and 4 are always 1.
- R11: While rdy is low, address, write enable, write data, sync and all internal state hold in every kind of cycle.
- R12: A falling edge on so_n sets status bit 6.
- R13: Any other fetched opcode takes one sync cycle and advances PC by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdy | input | 1 | High lets the current cycle complete |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive |
| irq_n | input | 1 | Maskable request, active low |
| so_n | input | 1 | Set-overflow, falling-edge sensitive |
| din | input | 8 | Read data for the current address |
| addr | output | 16 | Bus address |
| dout | output | 8 | Write data |
| we | output | 1 | Write strobe |
| sync | output | 1 | High in an opcode-fetch cycle |
| status | output | 8 | Processor status register |

## Verification
The bus outputs decode directly from the state register. Each cycle's address and write data are therefore due one clock edge after the edge that ended the previous cycle. The bench checks them at the falling edge between the two.

Status, stack pointer and PC changes land on the edge that ends the cycle that makes them. A vector or pulled status byte is therefore checked at the falling edge of the following fetch. A set-overflow edge shows in status one edge after it is applied.

For stalls, the bench holds rdy low for several cycles at chosen points and repeats the same comparison at every falling edge. The expected address stays fixed across the stall.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [7:0]  SP_INIT    = 8'hFD,
  parameter logic [7:0]  OP_BREAK   = 8'h00,
  parameter logic [7:0]  OP_RETURN  = 8'h40,
  parameter logic [15:0] VEC_NMI    = 16'hFFFA,
  parameter logic [15:0] VEC_RST    = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ    = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rdy,
  input  logic        nmi_n,
  input  logic        irq_n,
  input  logic        so_n,
  input  logic [7:0]  din,
  output logic [15:0] addr,
  output logic [7:0]  dout,
  output logic        we,
  output logic        sync,
  output logic [7:0]  status
);
  localparam logic [7:0] ONES = 8'h30;
  localparam int BIT_I = 2;
  localparam int BIT_D = 3;
  localparam int BIT_V = 6;

  typedef enum logic [3:0] {
    S_DEAD, S_RVL, S_RVH, S_FETCH, S_DUMMY, S_PSH_H, S_PSH_L, S_PSH_P,
    S_VECL, S_VECH, S_RET_D, S_RET_S, S_RET_P, S_RET_L, S_RET_H
  } state_t;

  typedef enum logic [1:0] {K_BRK, K_NMI, K_IRQ} kind_t;

  state_t      st;
  kind_t       kind;
  logic [15:0] pc;
  logic [7:0]  sp, p;
  logic        nmi_q, nmi_pend, so_q;

  wire [15:0] stk     = {STACK_PAGE, sp};
  wire [15:0] vec     = (kind == K_NMI) ? VEC_NMI : VEC_IRQ;
  wire        nmi_hit = nmi_pend | (nmi_q & ~nmi_n);
  wire        is_brk  = (din == OP_BREAK);
  wire        is_ret  = (din == OP_RETURN);
  wire        irq_go  = ~irq_n & ~p[BIT_I];
  wire        at_fetch = rdy && (st == S_FETCH);

  assign status = p;
  assign sync   = (st == S_FETCH);
  assign we     = (st == S_PSH_H) || (st == S_PSH_L) || (st == S_PSH_P);

  always_comb begin
    unique case (st)
      S_RVL:   addr = VEC_RST;
      S_RVH:   addr = VEC_RST | 16'd1;
      S_PSH_H, S_PSH_L, S_PSH_P,
      S_RET_S, S_RET_P, S_RET_L, S_RET_H: addr = stk;
      S_VECL:  addr = vec;
      S_VECH:  addr = vec | 16'd1;
      default: addr = pc;
    endcase
    unique case (st)
      S_PSH_H: dout = pc[15:8];
      S_PSH_L: dout = pc[7:0];
      S_PSH_P: dout = p | ONES;
      default: dout = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_DEAD;
      kind     <= K_BRK;
      pc       <= 16'h0000;
      sp       <= SP_INIT;
      p        <= ONES | 8'h04;
      nmi_q    <= 1'b1;
      nmi_pend <= 1'b0;
      so_q     <= 1'b1;
    end else begin
      nmi_q    <= nmi_n;
      so_q     <= so_n;
      nmi_pend <= nmi_hit && !(at_fetch && !is_brk);
      if (rdy) begin
        case (st)
          S_DEAD: st <= S_RVL;
          S_RVL: begin pc[7:0] <= din; st <= S_RVH; end
          S_RVH: begin pc[15:8] <= din; st <= S_FETCH; end
          S_FETCH: begin
            if (is_brk) begin
              kind <= K_BRK; pc <= pc + 16'd1; st <= S_DUMMY;
            end else if (nmi_hit) begin
              kind <= K_NMI; st <= S_DUMMY;
            end else if (irq_go) begin
              kind <= K_IRQ; st <= S_DUMMY;
            end else if (is_ret) begin
              pc <= pc + 16'd1; st <= S_RET_D;
            end else begin
              pc <= pc + 16'd1;
            end
          end
          S_DUMMY: begin
            if (kind == K_BRK) pc <= pc + 16'd1;
            st <= S_PSH_H;
          end
          S_PSH_H: begin sp <= sp - 8'd1; st <= S_PSH_L; end
          S_PSH_L: begin sp <= sp - 8'd1; st <= S_PSH_P; end
          S_PSH_P: begin sp <= sp - 8'd1; st <= S_VECL; end
          S_VECL: begin
            pc[7:0]  <= din;
            p[BIT_I] <= 1'b1;
            p[BIT_D] <= 1'b0;
            st       <= S_VECH;
          end
          S_VECH: begin pc[15:8] <= din; st <= S_FETCH; end
          S_RET_D: st <= S_RET_S;
          S_RET_S: begin sp <= sp + 8'd1; st <= S_RET_P; end
          S_RET_P: begin p <= din | ONES; sp <= sp + 8'd1; st <= S_RET_L; end
          S_RET_L: begin pc[7:0] <= din; sp <= sp + 8'd1; st <= S_RET_H; end
          S_RET_H: begin pc[15:8] <= din; st <= S_FETCH; end
          default: st <= S_DEAD;
        endcase
      end
      if (so_q && !so_n) p[BIT_V] <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rdy,
  input logic [15:0] addr,
  input logic [7:0]  dout,
  input logic        we,
  input logic        sync,
  input logic [7:0]  status
);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |=> $stable(addr) && $stable(we) && $stable(sync) && $stable(dout));

  p_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
    status[5:4] == 2'b11);

  p_stack_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> addr[15:8] == 8'h01);

  p_push_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && rdy) ##1 we |-> addr == $past(addr) - 16'd1);

  p_sync_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> !we);
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (.*);

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;
  logic clk = 1'b0;
  logic rst_n, rdy, nmi_n, irq_n, so_n;
  logic [7:0] din, dout, status;
  logic [15:0] addr;
  logic we, sync;

  int nchk = 0, nfail = 0, ncyc = 0;
  logic [15:0] epc;
  logic [7:0] esp, ep;
  logic [7:0] mem [0:1023];

  always #2.5 clk = ~clk;

  irq_entry_seq dut (.clk(clk), .rst_n(rst_n), .rdy(rdy), .nmi_n(nmi_n), .irq_n(irq_n),
    .so_n(so_n), .din(din), .addr(addr), .dout(dout), .we(we), .sync(sync), .status(status));

  function automatic logic [7:0] vecb(input logic [15:0] a);
    case (a)
      16'hFFFA: return 8'h00;
      16'hFFFB: return 8'h03;
      16'hFFFC: return 8'h00;
      16'hFFFD: return 8'h02;
      16'hFFFE: return 8'h80;
      16'hFFFF: return 8'h03;
      default:  return 8'hEA;
    endcase
  endfunction

  assign din = (addr < 16'h0400) ? mem[addr[9:0]] : vecb(addr);

  always @(posedge clk)
    if (rst_n && rdy && we && addr < 16'h0400) mem[addr[9:0]] <= dout;

  task automatic chk(input logic ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus(input logic [15:0] a, input logic w, input logic [7:0] d, input logic s,
                     input string tag, input int stall);
    logic [7:0] st0;
    st0 = status;
    chk(addr == a, tag, addr, a);
    chk(we == w, tag, we, w);
    chk(sync == s, tag, sync, s);
    if (w) chk(dout == d, tag, dout, d);
    for (int i = 0; i < stall; i++) begin
      rdy = 1'b0;
      @(negedge clk);
      chk(addr == a && we == w && sync == s && (!w || dout == d), "R11", addr, a);
      chk(status == st0, "R11", status, st0);
    end
    rdy = 1'b1;
    @(negedge clk);
  endtask

  task automatic fetch_nop();
    bus(epc, 1'b0, 8'h00, 1'b1, "R13", 0);
    epc = epc + 16'd1;
  endtask

  task automatic entry(input int kind, input string tv, input int scyc, input int sn);
    logic [15:0] ret, v;
    ret = (kind == 0) ? epc + 16'd2 : epc;
    v = (kind == 1) ? 16'hFFFA : 16'hFFFE;
    bus(epc, 1'b0, 8'h00, 1'b1, "R3", scyc == 1 ? sn : 0);
    bus(kind == 0 ? epc + 16'd1 : epc, 1'b0, 8'h00, 1'b0, kind == 0 ? "R6" : "R3", scyc == 2 ? sn : 0);
    bus({8'h01, esp}, 1'b1, ret[15:8], 1'b0, "R4", scyc == 3 ? sn : 0); esp--;
    bus({8'h01, esp}, 1'b1, ret[7:0], 1'b0, "R4", scyc == 4 ? sn : 0); esp--;
    bus({8'h01, esp}, 1'b1, ep | 8'h30, 1'b0, "R4", scyc == 5 ? sn : 0); esp--;
    bus(v, 1'b0, 8'h00, 1'b0, tv, scyc == 6 ? sn : 0);
    bus(v + 16'd1, 1'b0, 8'h00, 1'b0, tv, scyc == 7 ? sn : 0);
    epc = {vecb(v + 16'd1), vecb(v)};
    ep = ((ep | 8'h04) & 8'hF7) | 8'h30;
    chk(status == ep, "R6", status, ep);
    chk(sync && addr == epc, "R3", addr, epc);
  endtask

  task automatic ret_seq(input string t2, input int sn);
    logic [7:0] lo, hi;
    bus(epc, 1'b0, 8'h00, 1'b1, "R9", 0);
    bus(epc + 16'd1, 1'b0, 8'h00, 1'b0, t2, 0);
    bus({8'h01, esp}, 1'b0, 8'h00, 1'b0, "R9", sn); esp++;
    ep = mem[{2'b01, esp}] | 8'h30;
    bus({8'h01, esp}, 1'b0, 8'h00, 1'b0, "R9", 0); esp++;
    lo = mem[{2'b01, esp}];
    bus({8'h01, esp}, 1'b0, 8'h00, 1'b0, "R9", 0); esp++;
    hi = mem[{2'b01, esp}];
    bus({8'h01, esp}, 1'b0, 8'h00, 1'b0, "R9", 0);
    epc = {hi, lo};
    chk(status == ep, "R9", status, ep);
    chk(status[5:4] == 2'b11, "R10", status, ep);
    chk(sync && addr == epc, "R9", addr, epc);
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc == 20000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got %0d expected 0", ncyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'hEA;
    mem[10'h202] = 8'h00; mem[10'h203] = 8'h55;
    mem[10'h206] = 8'h00; mem[10'h207] = 8'h66;
    mem[10'h300] = 8'h40; mem[10'h380] = 8'h40;
    rst_n = 1'b0; rdy = 1'b1; nmi_n = 1'b1; irq_n = 1'b1; so_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sync == 1'b0 && we == 1'b0, "R1", {sync, we}, 0);
    chk(status == 8'h34, "R1", status, 8'h34);
    rst_n = 1'b1;
    chk(sync == 1'b0 && we == 1'b0, "R1", {sync, we}, 0);
    @(negedge clk);
    bus(16'hFFFC, 1'b0, 8'h00, 1'b0, "R1", 0);
    bus(16'hFFFD, 1'b0, 8'h00, 1'b0, "R1", 0);
    epc = 16'h0200; esp = 8'hFD; ep = 8'h34;
    chk(sync && addr == epc, "R1", addr, epc);
    chk(status[5:4] == 2'b11, "R10", status, ep);

    fetch_nop(); fetch_nop();
    entry(0, "R5", 0, 0);
    mem[10'h1FB] = 8'h89;
    ret_seq("R9", 2);

    irq_n = 1'b0;
    entry(2, "R5", 4, 3);
    ret_seq("R7", 0);
    entry(2, "R7", 0, 0);
    irq_n = 1'b1;
    ret_seq("R9", 0);

    irq_n = 1'b0; nmi_n = 1'b0;
    entry(1, "R2", 0, 0);
    ret_seq("R9", 0);
    entry(2, "R8", 0, 0);
    irq_n = 1'b1; nmi_n = 1'b1;
    ret_seq("R9", 0);

    fetch_nop(); fetch_nop();
    nmi_n = 1'b0;
    entry(0, "R2", 1, 2);
    chk(status[3] == 1'b0, "R6", status, ep);
    entry(1, "R2", 0, 0);
    nmi_n = 1'b1;
    ret_seq("R9", 0);
    ret_seq("R9", 0);
    chk(epc == 16'h0208, "R6", epc, 16'h0208);

    fetch_nop();
    so_n = 1'b0;
    fetch_nop();
    so_n = 1'b1;
    ep = ep | 8'h40;
    chk(status == ep, "R12", status, ep);
    fetch_nop();
    chk(status == ep, "R12", status, ep);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule